// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM. The RAM has a 17-bit address, an 8-bit data bus, two chip selects of opposite polarity (one active low, one active high), a write strobe and an output enable. The host issues one access at a time. It presents an address, write data and a direction flag with a single-cycle request strobe, then waits for a one-cycle done pulse. On a read, the done pulse comes with the returned byte.

Every memory timing minimum is a nanosecond parameter. The clock period is a parameter too, and each phase length is derived from these as a whole number of cycles, rounded up. The data bus is split into an output, an output-enable and an input, so that the pad ring can build the tristate driver. Output enable is held high for the whole of every write. After each read the controller waits out the memory's bus-release time before it returns to idle, so a following write never drives into the memory's own drivers.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and after it, the low-active select is 1 and the high-active select is 0. Write enable and output enable are both 1, the bus enable is 0 and done is 0.
- R2: On a write, both selects are asserted one cycle before write enable falls. Write enable then stays low for WP cycles. WP is the largest of ceil(tWP/T), ceil(tDW/T), ceil(tAW/T)-1 and ceil(tCW/T)-1, which gives 3 with the default parameters.
- R3: The bus enable is high, and the bus output carries the request's write data, in every cycle in which write enable is low. The bus enable is never high while output enable is low.
- R4: Output enable is 1 in every cycle in which write enable is 0.
- R5: The memory address only changes on an edge where write enable is 1, both in the cycle before the edge and in the cycle after it.
- R6: A read asserts both selects and output enable together, for RD = max(ceil(tAA/T), ceil(tACS/T), ceil(tOE/T), ceil(tRC/T)) + 1 cycles (5 by default). The returned byte is the bus value sampled RD-1 edges after the strobes assert.
- R7: After output enable rises at the end of a read, the bus enable does not rise within HZ = ceil(tHZ/T) cycles (2 by default).
- R8: Done is high for exactly one cycle per accepted request. On a read, rdata_o holds the returned byte while done is high.
- R9: A request that arrives while an access is in progress is ignored. It causes no memory write and no extra done pulse.
- R10: A written byte lands at the addressed location, including address 0x00000 and address 0x1FFFF. A later read of that location returns it, and a second write to the same location replaces it.
- R11: Counting the edge that accepts the request as edge 0, done is high in the cycle after edge 1+WP+WREC-1 for a write (edge 4 by default) and after edge RD+HZ-1 for a read (edge 6 by default). WREC is max(1, ceil(tWC/T)-1-WP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled only when idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Access address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with done on reads |
| mem_addr_o | output | 17 | Memory address |
| mem_sel_n_o | output | 1 | Low-active chip select |
| mem_sel_o | output | 1 | High-active chip select |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data bus output value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Data bus input value |

## Verification
The bench uses the default timing set with a 20 ns period parameter, which matches its 50 MHz clock. With these values the write pulse is set by the pulse-width minimum (3 cycles), not by the address-to-end minimum. The cycle-time minimum then forces a single recovery cycle, the read hold is 5 cycles and the bus-release wait is 2 cycles. Every rounding path therefore produces a distinct count that can be observed at the ports. The memory model returns a poison byte until four cycles of asserted read strobes have passed, so a read that captures one cycle early returns the wrong byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_REC,
    ST_R_ACC,
    ST_R_TURN
  } state_e;

  typedef struct packed {
    logic sel_n;
    logic sel;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } mem_ctl_t;

  // ceil(ns / per), never less than one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] dq_i,
  input  logic          capture_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] dq_sync_q;

  // first stage takes the asynchronous pin, second holds the result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_sync_q <= '0;
      rdata_o   <= '0;
    end else begin
      dq_sync_q <= dq_i;
      if (capture_i) rdata_o <= dq_sync_q;
    end
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 17,
  parameter int unsigned DW       = 8,
  parameter int unsigned CW       = 3,
  parameter int unsigned WP_CYC   = 3,
  parameter int unsigned WREC_CYC = 1,
  parameter int unsigned RD_CYC   = 5,
  parameter int unsigned HZ_CYC   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          cnt_last_i,
  output logic          cnt_load_o,
  output logic [CW-1:0] cnt_val_o,
  output logic          capture_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output mem_ctl_t      ctl_o
);

  state_e   state_q, state_d;
  mem_ctl_t ctl_d;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        cnt_load_o = 1'b1;
        if (req_we_i) begin
          state_d   = ST_W_SETUP;
          cnt_val_o = '0;
        end else begin
          state_d   = ST_R_ACC;
          cnt_val_o = CW'(RD_CYC - 1);
        end
      end
      ST_W_SETUP: if (cnt_last_i) begin
        state_d    = ST_W_PULSE;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(WP_CYC - 1);
      end
      ST_W_PULSE: if (cnt_last_i) begin
        state_d    = ST_W_REC;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(WREC_CYC - 1);
      end
      ST_W_REC: if (cnt_last_i) state_d = ST_IDLE;
      ST_R_ACC: if (cnt_last_i) begin
        state_d    = ST_R_TURN;
        cnt_load_o = 1'b1;
        cnt_val_o  = CW'(HZ_CYC - 1);
      end
      ST_R_TURN: if (cnt_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes follow the next state so they leave a flop
  always_comb begin
    ctl_d = '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    unique case (state_d)
      ST_W_SETUP: begin ctl_d.sel_n = 1'b0; ctl_d.sel = 1'b1; end
      ST_W_PULSE: begin
        ctl_d.sel_n = 1'b0; ctl_d.sel = 1'b1; ctl_d.we_n = 1'b0; ctl_d.dq_oe = 1'b1;
      end
      ST_W_REC:   ctl_d.dq_oe = 1'b1;
      ST_R_ACC:   begin ctl_d.sel_n = 1'b0; ctl_d.sel = 1'b1; ctl_d.oe_n = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ctl_o      <= '{sel_n: 1'b1, sel: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else begin
      state_q <= state_d;
      ctl_o   <= ctl_d;
      if (state_q == ST_IDLE && req_i) begin
        mem_addr_o <= req_addr_i;
        mem_dq_o   <= req_wdata_i;
      end
    end
  end

  assign capture_o = (state_q == ST_R_ACC) && cnt_last_i;
  assign done_o    = ((state_q == ST_W_REC) || (state_q == ST_R_TURN)) && cnt_last_i;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_CW_NS       = 60,
  parameter int unsigned T_WP_NS       = 45,
  parameter int unsigned T_DW_NS       = 30,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_ACS_NS      = 70,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned T_HZ_NS       = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_sel_n_o,
  output logic          mem_sel_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned WP_CYC   = umax(umax(ns2cyc(T_WP_NS, P), ns2cyc(T_DW_NS, P)),
                                          umax(ns2cyc(T_AW_NS, P) - 1, ns2cyc(T_CW_NS, P) - 1));
  localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, P);
  localparam int unsigned WREC_CYC = (WC_CYC > WP_CYC + 2) ? WC_CYC - 1 - WP_CYC : 1;
  localparam int unsigned RD_CYC   = umax(umax(ns2cyc(T_AA_NS, P), ns2cyc(T_ACS_NS, P)),
                                          umax(ns2cyc(T_OE_NS, P), ns2cyc(T_RC_NS, P))) + 1;
  localparam int unsigned HZ_CYC   = ns2cyc(T_HZ_NS, P);
  localparam int unsigned CNT_MAX  = umax(umax(WP_CYC, WREC_CYC), umax(RD_CYC, HZ_CYC));
  localparam int unsigned CW       = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  logic          cnt_load, cnt_last, capture;
  logic [CW-1:0] cnt_val;
  mem_ctl_t      ctl;

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .last_o     (cnt_last)
  );

  sram_ctrl_fsm #(
    .AW(AW), .DW(DW), .CW(CW),
    .WP_CYC(WP_CYC), .WREC_CYC(WREC_CYC), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .cnt_last_i  (cnt_last),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .capture_o   (capture),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .ctl_o       (ctl)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dq_i      (mem_dq_i),
    .capture_i (capture),
    .rdata_o   (rdata_o)
  );

  assign mem_sel_n_o = ctl.sel_n;
  assign mem_sel_o   = ctl.sel;
  assign mem_we_n_o  = ctl.we_n;
  assign mem_oe_n_o  = ctl.oe_n;
  assign mem_dq_oe_o = ctl.dq_oe;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW     = 17,
  parameter int unsigned WP_CYC = 3,
  parameter int unsigned HZ_CYC = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_sel_n_o,
  input logic          mem_sel_o,
  input logic          mem_we_n_o,
  input logic          mem_oe_n_o,
  input logic          mem_dq_oe_o
);

  int unsigned we_low_q;
  int unsigned oe_high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_q  <= 0;
      oe_high_q <= 1000;
    end else begin
      we_low_q  <= mem_we_n_o ? 0 : we_low_q + 1;
      if (!mem_oe_n_o)           oe_high_q <= 0;
      else if (oe_high_q < 1000) oe_high_q <= oe_high_q + 1;
    end
  end

  assert_sel_before_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> $past(!mem_sel_n_o && mem_sel_o));

  assert_we_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_low_q == WP_CYC));

  assert_no_drive_on_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !mem_dq_oe_o);

  assert_oe_off_in_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

  assert_addr_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_n_o && $past(mem_we_n_o)));

  assert_bus_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_high_q >= HZ_CYC));

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_sel_n_o (mem_sel_n_o),
  .mem_sel_o   (mem_sel_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int WP_EXP   = 3;   // 45 ns over 20 ns
  localparam int WR_LAT   = 4;
  localparam int RD_LAT   = 6;
  localparam int RD_VALID = 4;   // 70 ns access, whole cycles
  localparam int HZ_EXP   = 2;
  localparam logic [7:0] POISON = 8'hEE;
  localparam logic [7:0] BLANK  = 8'h99;

  // {write, addr, data}; data is the expected byte for reads
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'h3C},
    {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0AAAA, 8'h5A},
    {1'b0, 17'h00000, 8'h3C},
    {1'b0, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0AAAA, 8'hA5},
    {1'b0, 17'h0AAAA, 8'hA5},
    {1'b0, 17'h15555, BLANK},
    {1'b0, 17'h1FFFF, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        sel_n, sel, we_n, oe_n, dq_oe;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = POISON;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(mem_addr), .mem_sel_n_o(sel_n), .mem_sel_o(sel), .mem_we_n_o(we_n),
    .mem_oe_n_o(oe_n), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  // memory model, evaluated between edges
  logic [7:0]  mem_q [int unsigned];
  int          age = 0, wr_cnt = 0, gap = 100;
  logic        wr_prev = 1'b0, oe_prev = 1'b0;
  logic [16:0] wr_a = '0;
  logic [7:0]  wr_d = '0;
  logic        oe_bad = 1'b0, drv_bad = 1'b0, turn_bad = 1'b0;

  function automatic logic [7:0] peek(logic [16:0] a);
    return mem_q.exists(a) ? mem_q[a] : BLANK;
  endfunction

  always @(negedge clk) begin
    logic rd_on, wr_on;
    rd_on = !sel_n && sel && we_n && !oe_n;
    wr_on = !sel_n && sel && !we_n;
    age   = rd_on ? age + 1 : 0;
    if (wr_on) begin
      wr_cnt++;
      wr_a = mem_addr;
      wr_d = dq_oe ? dq_out : 8'h00;
      if (!oe_n) oe_bad = 1'b1;
      if (!dq_oe || dq_out != req_wdata) drv_bad = 1'b1;
    end else if (wr_prev) begin
      mem_q[wr_a] = wr_d;
    end
    wr_prev = wr_on;
    if (!oe_n) gap = 0; else if (gap < 100) gap++;
    if (dq_oe && !oe_prev && gap < HZ_EXP) turn_bad = 1'b1;
    oe_prev = dq_oe;
    if (rd_on) dq_in = (age >= RD_VALID) ? peek(mem_addr) : POISON;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d);
    int lat;
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    wr_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    chk(lat == (w ? WR_LAT : RD_LAT), "R11 latency", lat, w ? WR_LAT : RD_LAT);
    if (!w) chk(rdata == d, "R6 R10 read data", rdata, d);
    else    chk(wr_cnt == WP_EXP, "R2 write pulse width", wr_cnt, WP_EXP);
    @(negedge clk);
    chk(!done, "R8 done single cycle", done, 0);
  endtask

  task automatic chk_idle(input string tag);
    chk(sel_n && !sel && we_n && oe_n && !dq_oe && !done, tag,
        {sel_n, sel, we_n, oe_n, dq_oe, done}, 6'b101100);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dn;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 idle after reset");

    for (int i = 0; i < NV; i++)
      access(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);

    // R9: request held through a write; second address must stay untouched
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 17'h00100; req_wdata = 8'h11;
    @(posedge clk);
    @(negedge clk);
    req_addr = 17'h00200;
    dn = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (done) dn++;
    end
    req = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk(dn == 1, "R9 one done for busy request", dn, 1);
    access(1'b0, 17'h00200, BLANK);
    access(1'b0, 17'h00100, 8'h11);

    // R1: reset during a read releases every strobe at once
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 17'h00000;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 reset mid access");
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 17'h00000, 8'h3C);

    chk(!oe_bad, "R4 output enable high in write", oe_bad, 0);
    chk(!drv_bad, "R3 write data driven under strobe", drv_bad, 0);
    chk(!turn_bad, "R7 bus release wait", turn_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule